// File: doc/BRIEF.md
# Legacy Bus Address Decoder for a Disk Controller Board

This block generates the chip-select and strobe lines for a small disk controller board. On the board, an 8-bit microcontroller with a 680x-style E clock drives three devices:

- a floppy disk controller (FDC) with four registers,
- a 4K EPROM,
- a 1K static RAM.

The processor's read/write line is not used. Address bit A12 decides the transfer direction instead, and its polarity is opposite for the two devices. For the FDC, A12 high means a write. For the SRAM, A12 low pulls its write enable.

The FDC write strobe was once timed by an analog one-shot. Here a counter clocked by the fast system clock replaces it. The counter holds the strobe off until a fixed number of system clocks have passed with E high and A12 high. The strobe drops again on the first clock edge that sees either condition end.

Every output is taken from a flip-flop, so the outputs carry no decode glitches. Each output reflects the address and E sampled at the previous rising edge of the system clock. During reset, every active-low line is held high.

Top module: `mcu_map_decoder`

## Requirements
- R1: `fdc_rs[0]` equals A13 and `fdc_rs[1]` equals A14.
- R2: `fdc_cs_n` is low exactly when A11=1 and A15=0.
- R3: `fdc_rd_n` is low exactly when A12=0, E=1 and A15=0. With R1 and R2, this gives FDC reads at 0x0800, 0x2800, 0x4800 and 0x6800 (register selects 0 to 3).
- R4: `fdc_wr_n` goes low only on the DELAY_CYCLES-th consecutive clock edge that samples E=1 and A12=1. It stays low while both conditions hold. DELAY_CYCLES = ceil(DELAY_NS / CLK_PERIOD_NS). FDC writes thus land at 0x1800, 0x3800, 0x5800 and 0x7800.
- R5: `fdc_wr_n` returns high on the first clock edge that samples E=0 or A12=0. If the qualifying window is shorter than DELAY_CYCLES edges, no write strobe appears at all.
- R6: `rom_oe_n` is low exactly when A15=1 and E=1. Bits A12 to A14 do not affect it, so the 4K image repeats over 0x8000 to 0xFFFF.
- R7: `sram_ce_n` is low exactly when A10=1, E=1 and A15=0.
- R8: `sram_we_n` is low exactly when A12=0. The SRAM is therefore written from 0x0400 upward and read from 0x1400 upward.
- R9: While `rst_n` is low, all active-low outputs are high and `fdc_rs` is 0. After reset, each output follows the inputs sampled at the previous rising edge of `clk`.
- R10: In no cycle does more than one device drive read data. The three possible drivers are:
  - the FDC, when selected and read-strobed;
  - the EPROM, when its output is enabled;
  - the SRAM, when enabled with its write enable high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus; only A10 to A15 are decoded |
| e_clk | input | 1 | Processor E clock, high during the data phase |
| fdc_cs_n | output | 1 | FDC chip select, active low |
| fdc_rd_n | output | 1 | FDC read strobe, active low |
| fdc_wr_n | output | 1 | FDC write strobe, delayed, active low |
| fdc_rs | output | 2 | FDC register select (A14, A13) |
| rom_oe_n | output | 1 | EPROM output enable, active low |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bench builds the block with CLK_PERIOD_NS=20 and DELAY_NS=100, which gives a write delay of five clocks. With such a short delay, strobe timing can be checked edge by edge, including a window one clock too short and a write cut short by A12 falling.

Because only A10 to A15 and E take part in decoding, all 64 high-address combinations can be swept with E both low and high. At each vector, every output is compared with an expected value computed from masked address arithmetic, and the bench checks that at most one device drives read data.

// File: rtl/mcu_map_pkg.sv
package mcu_map_pkg;

  typedef struct packed {
    logic       fdc_cs;
    logic       fdc_rd;
    logic       wr_qual;
    logic       rom_oe;
    logic       sram_ce;
    logic       sram_wr;
    logic [1:0] rs;
  } sel_t;

  // Write-strobe delay in system clocks, rounded up.
  function automatic int unsigned delay_cycles(input int unsigned dly_ns,
                                               input int unsigned period_ns);
    return (dly_ns + period_ns - 1) / period_ns;
  endfunction

  // hi = {A15, A14, A13, A12, A11, A10}
  function automatic logic hit_fdc_cs(input logic [5:0] hi);
    return hi[1] & ~hi[5];
  endfunction

  function automatic logic hit_fdc_rd(input logic [5:0] hi, input logic e);
    return e & ~hi[2] & ~hi[5];
  endfunction

  function automatic logic hit_wr_qual(input logic [5:0] hi, input logic e);
    return e & hi[2];
  endfunction

  function automatic logic hit_rom(input logic [5:0] hi, input logic e);
    return e & hi[5];
  endfunction

  function automatic logic hit_sram_ce(input logic [5:0] hi, input logic e);
    return e & hi[0] & ~hi[5];
  endfunction

  function automatic logic hit_sram_wr(input logic [5:0] hi);
    return ~hi[2];
  endfunction

endpackage

// File: rtl/addr_map_decode.sv
module addr_map_decode
  import mcu_map_pkg::*;
(
  input  logic [5:0] addr_hi,
  input  logic       e_clk,
  output sel_t       sel
);
  always_comb begin
    sel.fdc_cs  = hit_fdc_cs(addr_hi);
    sel.fdc_rd  = hit_fdc_rd(addr_hi, e_clk);
    sel.wr_qual = hit_wr_qual(addr_hi, e_clk);
    sel.rom_oe  = hit_rom(addr_hi, e_clk);
    sel.sram_ce = hit_sram_ce(addr_hi, e_clk);
    sel.sram_wr = hit_sram_wr(addr_hi);
    sel.rs      = addr_hi[4:3];
  end
endmodule

// File: rtl/wr_delay_timer.sv
module wr_delay_timer #(
  parameter int unsigned DELAY_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  output logic fire
);
  localparam int unsigned CW = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt;

  // Strobe is due on the edge that completes DELAY_CYCLES qualifying samples.
  assign fire = qual && (cnt >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!qual)      cnt <= '0;
    else if (cnt < LAST) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mcu_map_decoder.sv
module mcu_map_decoder
  import mcu_map_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned DELAY_NS      = 400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        e_clk,
  output logic        fdc_cs_n,
  output logic        fdc_rd_n,
  output logic        fdc_wr_n,
  output logic [1:0]  fdc_rs,
  output logic        rom_oe_n,
  output logic        sram_ce_n,
  output logic        sram_we_n
);
  localparam int unsigned DELAY_CYCLES = delay_cycles(DELAY_NS, CLK_PERIOD_NS);

  sel_t sel;
  logic wr_fire;
  logic unused_low_addr;

  assign unused_low_addr = ^addr[9:0];

  addr_map_decode u_dec (
    .addr_hi (addr[15:10]),
    .e_clk   (e_clk),
    .sel     (sel)
  );

  wr_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .qual  (sel.wr_qual),
    .fire  (wr_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fdc_cs_n  <= 1'b1;
      fdc_rd_n  <= 1'b1;
      fdc_wr_n  <= 1'b1;
      fdc_rs    <= 2'b00;
      rom_oe_n  <= 1'b1;
      sram_ce_n <= 1'b1;
      sram_we_n <= 1'b1;
    end else begin
      fdc_cs_n  <= ~sel.fdc_cs;
      fdc_rd_n  <= ~sel.fdc_rd;
      fdc_wr_n  <= ~wr_fire;
      fdc_rs    <= sel.rs;
      rom_oe_n  <= ~sel.rom_oe;
      sram_ce_n <= ~sel.sram_ce;
      sram_we_n <= ~sel.sram_wr;
    end
  end
endmodule

// File: rtl/mcu_map_decoder_sva.sv
module mcu_map_decoder_sva #(
  parameter int unsigned DELAY_CYCLES = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        e_clk,
  input logic        fdc_cs_n,
  input logic        fdc_rd_n,
  input logic        fdc_wr_n,
  input logic [1:0]  fdc_rs,
  input logic        rom_oe_n,
  input logic        sram_ce_n,
  input logic        sram_we_n
);
  localparam int unsigned RW = $clog2(DELAY_CYCLES + 2);

  // Independent run-length count of qualifying write samples.
  logic [RW-1:0] run;
  logic          wq;
  logic [2:0]    drivers;

  assign wq = e_clk & addr[12];
  assign drivers = {~fdc_cs_n & ~fdc_rd_n, ~rom_oe_n, ~sram_ce_n & sram_we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run <= '0;
    else if (!wq)                 run <= '0;
    else if (run < RW'(DELAY_CYCLES)) run <= run + 1'b1;
  end

  p_rs_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fdc_rs == $past(addr[14:13]));

  p_fdc_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fdc_cs_n == !($past(addr[11]) && !$past(addr[15])));

  p_fdc_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fdc_rd_n == !($past(e_clk) && !$past(addr[12]) && !$past(addr[15])));

  p_wr_not_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fdc_wr_n |-> run >= RW'(DELAY_CYCLES));

  p_wr_on_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run >= RW'(DELAY_CYCLES)) |-> !fdc_wr_n);

  p_wr_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wq |=> fdc_wr_n);

  p_rom_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rom_oe_n == !($past(addr[15]) && $past(e_clk)));

  p_sram_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sram_ce_n == !($past(addr[10]) && $past(e_clk) && !$past(addr[15])));

  p_sram_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sram_we_n == $past(addr[12]));

  p_reset_idle_r9: assert property (@(posedge clk)
    !rst_n |=> (fdc_cs_n && fdc_rd_n && fdc_wr_n && rom_oe_n && sram_ce_n && sram_we_n
                && fdc_rs == 2'b00));

  p_one_driver_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drivers) <= 1);

endmodule

bind mcu_map_decoder mcu_map_decoder_sva #(.DELAY_CYCLES(DELAY_CYCLES)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .e_clk     (e_clk),
  .fdc_cs_n  (fdc_cs_n),
  .fdc_rd_n  (fdc_rd_n),
  .fdc_wr_n  (fdc_wr_n),
  .fdc_rs    (fdc_rs),
  .rom_oe_n  (rom_oe_n),
  .sram_ce_n (sram_ce_n),
  .sram_we_n (sram_we_n)
);

// File: tb/mcu_map_decoder_test.sv
module mcu_map_decoder_test;
  localparam int PERIOD = 20;
  localparam int DNS    = 100;
  localparam int DLY    = (DNS + PERIOD - 1) / PERIOD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        e_clk = 1'b0;
  logic        fdc_cs_n, fdc_rd_n, fdc_wr_n, rom_oe_n, sram_ce_n, sram_we_n;
  logic [1:0]  fdc_rs;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mcu_map_decoder #(.CLK_PERIOD_NS(PERIOD), .DELAY_NS(DNS)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .e_clk(e_clk),
    .fdc_cs_n(fdc_cs_n), .fdc_rd_n(fdc_rd_n), .fdc_wr_n(fdc_wr_n),
    .fdc_rs(fdc_rs), .rom_oe_n(rom_oe_n), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Output vector {cs,rd,wr,rs,oe,ce,we} expected one clock after (a,e) for a short access.
  function automatic logic [7:0] expect_vec(input logic [15:0] a, input logic e);
    logic cs, rd, oe, ce, we;
    logic [1:0] rs;
    cs = !((a & 16'h8800) == 16'h0800);
    rd = !(((a & 16'h9000) == 16'h0000) && e);
    rs = 2'((a >> 13) % 4);
    oe = !((a >= 16'h8000) && e);
    ce = !(((a & 16'h8400) == 16'h0400) && e);
    we = (a & 16'h1000) != 16'h0000;
    return {cs, rd, 1'b1, rs, oe, ce, we};
  endfunction

  function automatic logic [7:0] actual_vec();
    return {fdc_cs_n, fdc_rd_n, fdc_wr_n, fdc_rs, rom_oe_n, sram_ce_n, sram_we_n};
  endfunction

  task automatic idle();
    @(negedge clk);
    e_clk = 1'b0;
    addr  = 16'h0000;
  endtask

  // Hold a qualifying write window for n edges and check the strobe at each edge (R4/R5).
  task automatic write_window(input logic [15:0] a, input int n, input bit cut_by_a12);
    @(negedge clk);
    addr  = a;
    e_clk = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check((k >= DLY) ? "R4 strobe due" : "R4 strobe early",
            32'(fdc_wr_n), (k >= DLY) ? 32'd0 : 32'd1);
    end
    if (cut_by_a12) addr = a & 16'hEFFF;
    else            e_clk = 1'b0;
    @(negedge clk);
    check("R5 release", 32'(fdc_wr_n), 32'd1);
    idle();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [2:0]  drv;
    // R9: reset state
    repeat (3) @(negedge clk);
    addr  = 16'h7800;
    e_clk = 1'b1;
    @(negedge clk);
    check("R9 reset outputs", 32'(actual_vec()), 32'(8'b1110_0111));
    rst_n = 1'b1;
    idle();
    @(negedge clk);

    // Sweep A15..A10 with E low and high: R1 R2 R3 R6 R7 R8 R9 and R10
    for (int hi = 0; hi < 64; hi++) begin
      for (int ev = 0; ev < 2; ev++) begin
        @(negedge clk);
        a = 16'((hi * 1024) + 16'h02A5);
        addr  = a;
        e_clk = 1'(ev);
        @(negedge clk);
        check("R1 R2 R3 R6 R7 R8 sweep", 32'(actual_vec()), 32'(expect_vec(a, 1'(ev))));
        drv = {~fdc_cs_n & ~fdc_rd_n, ~rom_oe_n, ~sram_ce_n & sram_we_n};
        check("R10 single driver", 32'(drv == 3'b000 || drv == 3'b001 ||
                                       drv == 3'b010 || drv == 3'b100), 32'd1);
        idle();
      end
    end

    // R3 + R1: the four FDC read addresses select registers 0..3
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      addr = 16'(16'h0800 + r * 16'h2000);
      e_clk = 1'b1;
      @(negedge clk);
      check("R3 fdc read strobe", 32'(fdc_rd_n), 32'd0);
      check("R1 register select", 32'(fdc_rs), 32'(r));
      idle();
    end

    // R4: full write window at each FDC write address, then drop E (R5)
    for (int r = 0; r < 4; r++)
      write_window(16'(16'h1800 + r * 16'h2000), DLY + 3, 1'b0);
    // R5: window one edge too short gives no strobe
    write_window(16'h3800, DLY - 1, 1'b0);
    // R5: A12 falling while E stays high ends the strobe
    write_window(16'h5800, DLY + 1, 1'b1);

    // R6: EPROM mirror across A12..A14 at E high
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      addr = 16'(16'h8123 + m * 16'h1000);
      e_clk = 1'b1;
      @(negedge clk);
      check("R6 rom mirror", 32'(rom_oe_n), 32'd0);
      idle();
    end

    // R7/R8: SRAM write at 0x0400 and read at 0x1400
    @(negedge clk); addr = 16'h0400; e_clk = 1'b1;
    @(negedge clk);
    check("R7 sram enable write side", 32'(sram_ce_n), 32'd0);
    check("R8 sram write enable low", 32'(sram_we_n), 32'd0);
    idle();
    @(negedge clk); addr = 16'h1400; e_clk = 1'b1;
    @(negedge clk);
    check("R7 sram enable read side", 32'(sram_ce_n), 32'd0);
    check("R8 sram write enable high", 32'(sram_we_n), 32'd1);
    idle();

    // R9: reset reasserted mid-write clears strobes at once
    @(negedge clk); addr = 16'h1800; e_clk = 1'b1;
    repeat (DLY + 1) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async reset", 32'(actual_vec()), 32'(8'b1110_0111));
    @(negedge clk);
    rst_n = 1'b1;
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule